// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides a double-width dividend by a single-width divisor. Each operand comes as a data word plus a separate sign flag. When the sign flag of an operand is set, its word holds the two's-complement encoding of the negative value. The block first turns both operands into magnitudes. It then screens out divide-by-zero, quotient overflow and the trivial zero-quotient case. If none of these applies, it runs one shift, subtract and restore step per clock until all quotient bits are formed. At the end it puts the signs back onto the quotient and the remainder.

A host presents the operands and pulses `start` for one cycle. `busy` then stays high until the cycle in which `done` pulses. The results and flags stay on the outputs until the next accepted start.

The controller has four states:
- `ST_IDLE` waits for a start.
- `ST_CHECK` screens the magnitudes.
- `ST_ITER` performs the division steps.
- `ST_FIX` applies the signs.

Its transitions are:
- IDLE→CHECK when start is seen.
- CHECK→IDLE when an error is found.
- CHECK→FIX for a zero quotient.
- CHECK→ITER otherwise.
- ITER→ITER until the last step, then ITER→FIX.
- FIX→IDLE, which always happens.

Top module: `smdiv_top`

## Requirements
- R1: The quotient sign flag equals the XOR of the two operand sign flags, and the remainder sign flag equals the dividend sign flag. When the quotient sign flag is set, the quotient word is the two's complement of the quotient magnitude; the remainder word follows the same rule with its own flag.
- R2: When `dvd_neg` is 1, the dividend magnitude is the two's complement of {dvd_hi, dvd_lo}, 2W bits wide. When `dvs_neg` is 1, the divisor magnitude is the two's complement of `dvs`. When a sign flag is 0, the word is the magnitude itself.
- R3: A zero divisor magnitude sets `dz`, clears `ovf`, and drives both result words and both result sign flags to 0. `done` pulses one cycle after the start edge.
- R4: A nonzero divisor magnitude that is less than or equal to the high word of the dividend magnitude sets `ovf`, clears `dz`, and drives both result words and both result sign flags to 0. `done` pulses one cycle after the start edge.
- R5: When the high word of the dividend magnitude is zero and the low word is below the divisor magnitude, no steps are run. The quotient magnitude is 0, the remainder magnitude is the low word, and `done` pulses two cycles after the start edge.
- R6: In every other case the results equal signed division truncated toward zero, with the remainder carrying the dividend's sign. Exactly W steps are run, and `done` pulses W+2 cycles after the start edge.
- R7: A `start` pulse while `busy` is high has no effect on the running operation or its results.
- R8: After reset, `busy`, `done`, `ovf` and `dz` are 0. `done` is high for exactly one cycle, `busy` falls in that same cycle, and the outputs hold their values while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dvd_hi | input | W | Upper word of the dividend encoding |
| dvd_lo | input | W | Lower word of the dividend encoding |
| dvd_neg | input | 1 | Dividend is negative |
| dvs | input | W | Divisor encoding |
| dvs_neg | input | 1 | Divisor is negative |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quo | output | W | Quotient word |
| quo_neg | output | 1 | Quotient sign flag |
| rem | output | W | Remainder word |
| rem_neg | output | 1 | Remainder sign flag |
| ovf | output | 1 | Quotient would not fit in W bits |
| dz | output | 1 | Divisor magnitude was zero |

## Verification
The bench builds the block with its default width of 8. This makes a 16-bit dividend and an 8-bit divisor, so the largest quotient (255) is reachable. The boundary where the high word equals the divisor is reachable, and so is a negative zero operand, all with ordinary integer arithmetic in the reference model.

At this width, random operands kept below the overflow limit cover the full spread of quotient magnitudes. Directed items cover each screening path, both sign combinations on every path, and the per-path completion latency.

// File: rtl/smdiv_pkg.sv
package smdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ITER,
        ST_FIX
    } dstate_t;
endpackage

// File: rtl/smdiv_cneg.sv
// Conditional two's-complement: passes the word through or negates it.
module smdiv_cneg #(
    parameter int WD = 8
) (
    input  logic [WD-1:0] val,
    input  logic          neg,
    output logic [WD-1:0] res
);
    always_comb begin
        res = neg ? (~val + WD'(1)) : val;
    end
endmodule

// File: rtl/smdiv_step.sv
// One restoring step: shift the partial remainder left, trial-subtract the divisor,
// add it back when the trial goes negative, and shift in the quotient bit.
module smdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] b,
    output logic [W-1:0] a_out,
    output logic [W-1:0] q_out
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic [W:0] restored;
    logic       went_neg;

    always_comb begin
        shifted  = {a_in, q_in[W-1]};
        trial    = shifted - {1'b0, b};
        restored = trial + {1'b0, b};
        went_neg = trial[W];
        a_out    = went_neg ? restored[W-1:0] : trial[W-1:0];
        q_out    = {q_in[W-2:0], ~went_neg};
    end
endmodule

// File: rtl/smdiv_top.sv
module smdiv_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic         dvd_neg,
    input  logic [W-1:0] dvs,
    input  logic         dvs_neg,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic         quo_neg,
    output logic [W-1:0] rem,
    output logic         rem_neg,
    output logic         ovf,
    output logic         dz
);
    import smdiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(W + 1);

    dstate_t        state, nstate;
    logic [W-1:0]   a_r, q_r, b_r;
    logic           qs_r, rs_r;
    logic [CW-1:0]  cnt;
    logic [DW-1:0]  dvd_mag;
    logic [W-1:0]   dvs_mag;
    logic [W-1:0]   step_a, step_q;
    logic [W-1:0]   quo_fix, rem_fix;
    logic           is_zero_div, is_ovf, is_trivial, last_step;

    smdiv_cneg #(.WD(DW)) u_dvd_mag (.val({dvd_hi, dvd_lo}), .neg(dvd_neg), .res(dvd_mag));
    smdiv_cneg #(.WD(W))  u_dvs_mag (.val(dvs), .neg(dvs_neg), .res(dvs_mag));
    smdiv_cneg #(.WD(W))  u_quo_fix (.val(q_r), .neg(qs_r), .res(quo_fix));
    smdiv_cneg #(.WD(W))  u_rem_fix (.val(a_r), .neg(rs_r), .res(rem_fix));

    smdiv_step #(.W(W)) u_step (
        .a_in (a_r),
        .q_in (q_r),
        .b    (b_r),
        .a_out(step_a),
        .q_out(step_q)
    );

    always_comb begin
        is_zero_div = (b_r == '0);
        is_ovf      = (a_r >= b_r);
        is_trivial  = (a_r == '0) && (q_r < b_r);
        last_step   = (cnt == CW'(W - 1));
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_CHECK;
            ST_CHECK: begin
                if (is_zero_div || is_ovf) nstate = ST_IDLE;
                else if (is_trivial)       nstate = ST_FIX;
                else                       nstate = ST_ITER;
            end
            ST_ITER:  if (last_step) nstate = ST_FIX;
            ST_FIX:   nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_r     <= '0;
            q_r     <= '0;
            b_r     <= '0;
            qs_r    <= 1'b0;
            rs_r    <= 1'b0;
            cnt     <= '0;
            quo     <= '0;
            rem     <= '0;
            quo_neg <= 1'b0;
            rem_neg <= 1'b0;
            ovf     <= 1'b0;
            dz      <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_r     <= dvd_mag[DW-1:W];
                        q_r     <= dvd_mag[W-1:0];
                        b_r     <= dvs_mag;
                        qs_r    <= dvd_neg ^ dvs_neg;
                        rs_r    <= dvd_neg;
                        cnt     <= '0;
                        quo     <= '0;
                        rem     <= '0;
                        quo_neg <= 1'b0;
                        rem_neg <= 1'b0;
                        ovf     <= 1'b0;
                        dz      <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    if (is_zero_div) begin
                        dz   <= 1'b1;
                        done <= 1'b1;
                    end else if (is_ovf) begin
                        ovf  <= 1'b1;
                        done <= 1'b1;
                    end else if (is_trivial) begin
                        a_r <= q_r;
                        q_r <= '0;
                    end
                end
                ST_ITER: begin
                    a_r <= step_a;
                    q_r <= step_q;
                    cnt <= cnt + CW'(1);
                end
                ST_FIX: begin
                    quo     <= quo_fix;
                    rem     <= rem_fix;
                    quo_neg <= qs_r;
                    rem_neg <= rs_r;
                    done    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/smdiv_chk.sv
module smdiv_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quo,
    input logic         quo_neg,
    input logic [W-1:0] rem,
    input logic         rem_neg,
    input logic         ovf,
    input logic         dz
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quo) && $stable(rem) && $stable(ovf) && $stable(dz)));
    // R7
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
    // R3
    dz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dz) |-> (!ovf && quo == '0 && rem == '0 && !quo_neg && !rem_neg));
    // R4
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (!dz && quo == '0 && rem == '0 && !quo_neg && !rem_neg));
endmodule

bind smdiv_top smdiv_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .quo    (quo),
    .quo_neg(quo_neg),
    .rem    (rem),
    .rem_neg(rem_neg),
    .ovf    (ovf),
    .dz     (dz)
);

// File: tb/sim_smdiv_top.sv
module sim_smdiv_top;
    localparam int W = 8;
    localparam int DW = 2 * W;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [W-1:0] q;
        logic         qn;
        logic [W-1:0] r;
        logic         rn;
        logic         ov;
        logic         z;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic dvd_neg = 1'b0, dvs_neg = 1'b0;
    logic busy, done, quo_neg, rem_neg, ovf, dz;
    logic [W-1:0] quo, rem;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t expq[$];
    string tagq[$];
    exp_t last_exp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smdiv_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvd_neg(dvd_neg),
        .dvs(dvs), .dvs_neg(dvs_neg),
        .busy(busy), .done(done),
        .quo(quo), .quo_neg(quo_neg), .rem(rem), .rem_neg(rem_neg),
        .ovf(ovf), .dz(dz)
    );

    task automatic check(input bit ok, input string what, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", what, act, exp);
        end
    endtask

    // Monitor: pops expected items when the design signals completion
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            if (expq.size() == 0) begin
                check(1'b0, "R8 unexpected done", "done", "no pending item");
            end else begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                last_exp = e;
                check({quo, quo_neg, rem, rem_neg, ovf, dz} == e, t,
                      $sformatf("q=%0h qn=%0b r=%0h rn=%0b ov=%0b z=%0b", quo, quo_neg, rem, rem_neg, ovf, dz),
                      $sformatf("q=%0h qn=%0b r=%0h rn=%0b ov=%0b z=%0b", e.q, e.qn, e.r, e.rn, e.ov, e.z));
            end
        end
    end

    // Driver: computes the expected item from the requirements, then runs the operation
    task automatic run_op(input bit sd, input logic [DW-1:0] dm, input bit sb,
                          input logic [W-1:0] bm, input bit intrude, input string tag);
        exp_t e;
        int lat, cnt, dv, bv, qv, rv;
        logic [DW-1:0] enc;
        logic [W-1:0] benc;
        e = '0;
        if (bm == 0) begin
            e.z = 1'b1; lat = 1;                                  // R3
        end else if (dm[DW-1:W] >= bm) begin
            e.ov = 1'b1; lat = 1;                                 // R4
        end else begin
            dv = sd ? -int'(dm) : int'(dm);
            bv = sb ? -int'(bm) : int'(bm);
            qv = dv / bv;                                         // R6 truncating division
            rv = dv % bv;
            e.q = W'(qv);
            e.r = W'(rv);
            e.qn = sd ^ sb;                                       // R1
            e.rn = sd;
            lat = (dm[DW-1:W] == 0 && dm[W-1:0] < bm) ? 2 : W + 2; // R5 / R6
        end
        enc  = sd ? (DW'(0) - dm) : dm;                           // R2 encoding
        benc = sb ? (W'(0) - bm) : bm;
        expq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
        {dvd_hi, dvd_lo} = enc;
        dvs = benc; dvd_neg = sd; dvs_neg = sb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin                                        // R7: start while busy
            {dvd_hi, dvd_lo} = DW'(16'h00FF);
            dvs = W'(1); dvd_neg = ~sd; dvs_neg = 1'b0;
            start = 1'b1;
        end
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            start = 1'b0;
        end while (!done && cnt < 40);
        check(cnt == lat, {tag, " latency"}, $sformatf("%0d", cnt), $sformatf("%0d", lat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check({busy, done, ovf, dz} == 4'b0, "R8 reset", $sformatf("%b", {busy, done, ovf, dz}), "0000");
        rst_n = 1'b1;
        @(negedge clk);

        run_op(0, 16'd100, 0, 8'd7,   0, "R6 pos/pos");
        run_op(1, 16'd100, 0, 8'd7,   0, "R1 neg/pos");
        run_op(0, 16'd100, 1, 8'd7,   0, "R1 pos/neg");
        run_op(1, 16'd100, 1, 8'd7,   0, "R2 neg/neg");
        run_op(0, 16'h12FF, 0, 8'h13, 0, "R6 large");
        run_op(1, 16'hFEFF, 1, 8'hFF, 0, "R6 max quotient");
        run_op(0, 16'd500, 0, 8'd0,   0, "R3 zero divisor");
        run_op(1, 16'd500, 1, 8'd0,   0, "R3 zero divisor signed");
        run_op(0, 16'h0500, 0, 8'h05, 0, "R4 hi equals divisor");
        run_op(1, 16'h0900, 0, 8'h05, 0, "R4 hi above divisor");
        run_op(0, 16'd3, 0, 8'd9,     0, "R5 small dividend");
        run_op(1, 16'd3, 1, 8'd9,     0, "R5 small negative");
        run_op(1, 16'd0, 0, 8'd9,     0, "R5 negative zero");
        run_op(0, 16'd9, 0, 8'd9,     0, "R6 equal low word");
        run_op(1, 16'h0ABC, 0, 8'h21, 1, "R7 start ignored");
        run_op(0, 16'd0, 0, 8'd0,     1, "R7 start ignored on error");

        // R8 hold while idle
        repeat (5) @(negedge clk);
        check({quo, rem, ovf, dz} == {last_exp.q, last_exp.r, last_exp.ov, last_exp.z}, "R8 hold",
              $sformatf("%0h %0h", quo, rem), $sformatf("%0h %0h", last_exp.q, last_exp.r));

        // R6 random operands below the overflow limit
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] bm, hi, lo;
            bm = W'($urandom_range(1, (1 << W) - 1));
            hi = W'($urandom_range(0, int'(bm) - 1));
            lo = W'($urandom);
            run_op(1'($urandom), {hi, lo}, 1'($urandom), bm, 0, "R6 random");
        end
        // R3 / R4 random error cases
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] bm;
            bm = W'($urandom_range(0, 40));
            run_op(1'($urandom), {W'($urandom_range(int'(bm), (1 << W) - 1)), W'($urandom)},
                   1'($urandom), bm, 0, "R4 random error");
        end
        @(negedge clk);
        check(expq.size() == 0, "R8 all results seen", $sformatf("%0d", expq.size()), "0");
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule